// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Control Register

This block is a single 64-bit control and status register shared by four processors. It keeps one interprocessor interrupt pending flag and one interval timer interrupt pending flag per processor. It also holds two small arbitration fields that processors use to claim ownership, and a 4-bit general storage field. Each field has its own write rule: some bits are cleared by writing one, some are set by writing one, one field can only be set while it is empty, and a request field raises interrupts on other processors. One write can raise interprocessor interrupts on some processors and clear them on others.

Every pending flag drives an output line. The interprocessor lines follow their flags after every write, so they can rise or fall. The timer lines are raised only by per-processor strobes from the interval timer, and a register write can only lower them. A read returns the stored value with its two lowest bits replaced by the index of the processor that issued the read, so software can tell which processor it is running on.

Top module: `ipi_timer_ctl`

## Requirements
- R1: After reset every stored bit is 0, `ipi_irq` and `timer_irq` are 0 and `rdata` is 0.
- R2: A write with a 1 in bits 11:4 (pending flags) or bit 28 clears that bit. Bit 28 has no setting source and always reads 0.
- R3: A write with bit 20 set first clears the whole arbitration byte at bits 23:16, and only then applies the set rules of the same write.
- R4: Bits 23:20 are write-one-to-set: a 1 written there sets the bit and a 0 leaves it unchanged.
- R5: Bits 19:16 take write-one-to-set only when the field is 0 after the clear step of the same write. Otherwise the written value is ignored, so the first writer keeps the field.
- R6: A 1 in request bit 12+i sets pending bit 8+i. The request is applied after the clear step, so a request wins over a clear of the same bit in the same write.
- R7: Bits 43:40 hold the written value on every write.
- R8: `ipi_irq[i]` equals stored bit 8+i and changes in the cycle after the write that changes it, rising or falling.
- R9: `timer_set[i]` sets stored bit 4+i and `timer_irq[i]` in the next cycle, even when a write in the same cycle clears that bit. A write alone never sets bits 7:4.
- R10: `rd_en` loads `rdata` one cycle later with the stored value, with bits 1:0 replaced by `cpu_id`. A write in the same cycle is not yet visible. `rdata` holds between reads.
- R11: Bits 63:44, 39:29, 27:24 and 3:0 ignore writes and read as 0, apart from the `cpu_id` merge in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `wdata` |
| wdata | input | 64 | Write value, applied with per-field rules |
| rd_en | input | 1 | Read strobe |
| cpu_id | input | 2 | Index of the processor that issued the read |
| timer_set | input | 4 | Per-processor interval timer strobes |
| rdata | output | 64 | Read value, registered |
| ipi_irq | output | 4 | Interprocessor interrupt per processor |
| timer_irq | output | 4 | Interval timer interrupt per processor |

## Verification
The write merge is driven with values that each hit one rule alone: only requests, only clears, and only arbitration bits. It is also driven with values that combine rules in one write: a clear and a request on the same bit, the byte clear plus the set fields, and a second claim on a field that is already taken. These combinations show whether the clear-then-set order is honoured. Timer strobes are given with and without a clearing write in the same cycle, which separates strobe priority from write behaviour. Reads from different processor indices, a read in the same cycle as a write, and an all-ones write to the unused bits show the id merge, the old-value timing and the ignored bits.

// File: rtl/misc_ctl_pkg.sv
package misc_ctl_pkg;
  localparam int DATA_W   = 64;
  localparam int NCPU     = 4;
  localparam int ID_W     = $clog2(NCPU);
  localparam int ITI_LO   = 4;
  localparam int IPI_LO   = 8;
  localparam int REQ_LO   = 12;
  localparam int WIN_LO   = 16;
  localparam int ARB_CLR  = 20;

  localparam logic [DATA_W-1:0] W1C_MASK = 64'h0000_0000_1000_0FF0;
  localparam logic [DATA_W-1:0] ARB_MASK = 64'h0000_0000_00FF_0000;
  localparam logic [DATA_W-1:0] BID_MASK = 64'h0000_0000_00F0_0000;
  localparam logic [DATA_W-1:0] WIN_MASK = 64'h0000_0000_000F_0000;
  localparam logic [DATA_W-1:0] REQ_MASK = 64'h0000_0000_0000_F000;
  localparam logic [DATA_W-1:0] RW_MASK  = 64'h0000_0F00_0000_0000;

  // Clear step first, then the set fields, then the plain storage.
  function automatic logic [DATA_W-1:0] merge_write(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] val);
    logic [DATA_W-1:0] n;
    n = cur & ~(val & W1C_MASK);
    if (val[ARB_CLR]) n = n & ~ARB_MASK;
    n = n | (val & BID_MASK);
    if ((n & WIN_MASK) == '0) n = n | (val & WIN_MASK);
    n = n | ((val & REQ_MASK) >> (REQ_LO - IPI_LO));
    n = (n & ~RW_MASK) | (val & RW_MASK);
    return n;
  endfunction

  function automatic logic [DATA_W-1:0] read_view(input logic [DATA_W-1:0] cur,
                                                  input logic [ID_W-1:0] id);
    return {cur[DATA_W-1:ID_W], id};
  endfunction
endpackage

// File: rtl/misc_next.sv
module misc_next
  import misc_ctl_pkg::*;
(
  input  logic [DATA_W-1:0] state_q,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCPU-1:0]   timer_set,
  output logic [DATA_W-1:0] state_d
);
  logic [DATA_W-1:0] after_wr;
  logic [DATA_W-1:0] iti_bits;

  always_comb begin
    after_wr = wr_en ? merge_write(state_q, wdata) : state_q;
    iti_bits = DATA_W'(timer_set) << ITI_LO;
    state_d  = after_wr | iti_bits;
  end
endmodule

// File: rtl/misc_read_port.sv
module misc_read_port
  import misc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ID_W-1:0]   cpu_id,
  input  logic [DATA_W-1:0] state_q,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= read_view(state_q, cpu_id);
  end
endmodule

// File: rtl/ipi_timer_ctl.sv
module ipi_timer_ctl
  import misc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [ID_W-1:0]   cpu_id,
  input  logic [NCPU-1:0]   timer_set,
  output logic [DATA_W-1:0] rdata,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   timer_irq
);
  logic [DATA_W-1:0] state_q;
  logic [DATA_W-1:0] state_d;
  logic [3:0]        win_field;

  misc_next u_next (
    .state_q   (state_q),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .timer_set (timer_set),
    .state_d   (state_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  misc_read_port u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .cpu_id  (cpu_id),
    .state_q (state_q),
    .rdata   (rdata)
  );

  assign ipi_irq   = state_q[IPI_LO +: NCPU];
  assign timer_irq = state_q[ITI_LO +: NCPU];
  assign win_field = state_q[WIN_LO +: 4];
endmodule

// File: rtl/misc_ctl_chk.sv
module misc_ctl_chk
  import misc_ctl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [NCPU-1:0] req_bits,
  input logic            arb_clr,
  input logic [ID_W-1:0] cpu_id,
  input logic [ID_W-1:0] rd_id,
  input logic [NCPU-1:0] timer_set,
  input logic [NCPU-1:0] ipi_irq,
  input logic [NCPU-1:0] timer_irq,
  input logic [3:0]      win_field
);
  // R6
  req_sets_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_bits != '0) |=> ((ipi_irq & $past(req_bits)) == $past(req_bits)));

  // R9
  strobe_sets_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_set != '0) |=> ((timer_irq & $past(timer_set)) == $past(timer_set)));

  // R9
  write_never_raises_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_set == '0) |=> ((timer_irq & ~$past(timer_irq)) == '0));

  // R8
  idle_holds_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && timer_set == '0) |=> ($stable(ipi_irq) && $stable(timer_irq)));

  // R10
  read_id_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_id == $past(cpu_id)));

  // R5
  claim_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_field != 4'h0 && !(wr_en && arb_clr)) |=> $stable(win_field));
endmodule

bind ipi_timer_ctl misc_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .req_bits  (wdata[15:12]),
  .arb_clr   (wdata[20]),
  .cpu_id    (cpu_id),
  .rd_id     (rdata[1:0]),
  .timer_set (timer_set),
  .ipi_irq   (ipi_irq),
  .timer_irq (timer_irq),
  .win_field (win_field)
);

// File: tb/sim_ipi_timer_ctl.sv
module sim_ipi_timer_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  cpu_id = '0;
  logic [3:0]  timer_set = '0;
  logic [63:0] rdata;
  logic [3:0]  ipi_irq;
  logic [3:0]  timer_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] model = '0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 0;

  always #10 clk = ~clk;

  ipi_timer_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .cpu_id(cpu_id), .timer_set(timer_set), .rdata(rdata),
    .ipi_irq(ipi_irq), .timer_irq(timer_irq)
  );

  // Bench-side restatement, bit by bit.
  function automatic logic [63:0] ref_write(input logic [63:0] m, input logic [63:0] v);
    logic [63:0] r = m;
    for (int b = 4; b < 12; b++) if (v[b]) r[b] = 1'b0;
    if (v[28]) r[28] = 1'b0;
    if (v[20]) for (int b = 16; b < 24; b++) r[b] = 1'b0;
    for (int b = 20; b < 24; b++) if (v[b]) r[b] = 1'b1;
    if (r[19:16] == 4'd0) r[19:16] = v[19:16];
    for (int c = 0; c < 4; c++) if (v[12+c]) r[8+c] = 1'b1;
    r[43:40] = v[43:40];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; read expectations go to the scoreboard.
  task automatic op(input string tag, input bit wr, input logic [63:0] v,
                    input bit rd, input logic [1:0] id, input logic [3:0] ts);
    @(negedge clk);
    wr_en = wr; wdata = v; rd_en = rd; cpu_id = id; timer_set = ts;
    if (rd) begin
      exp_q.push_back({model[63:2], id});
      tag_q.push_back(tag);
    end
    if (wr) model = ref_write(model, v);
    for (int c = 0; c < 4; c++) if (ts[c]) model[4+c] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; rd_en = 1'b0; timer_set = '0;
    check({tag, " R8 ipi"}, 64'(ipi_irq), 64'(model[11:8]));
    check({tag, " R9 timer"}, 64'(timer_irq), 64'(model[7:4]));
  endtask

  task automatic wr(input string tag, input logic [63:0] v);
    op(tag, 1'b1, v, 1'b0, 2'd0, 4'd0);
  endtask

  task automatic rd(input string tag, input logic [1:0] id);
    op(tag, 1'b0, '0, 1'b1, id, 4'd0);
  endtask

  // Monitor
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 unexpected read actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 rdata", rdata, '0);
    check("R1 irq", 64'({ipi_irq, timer_irq}), '0);
    rst_n = 1'b1;
    rd("R1 R10 id2", 2'd2);
    wr("R6 req 0,2", 64'h5000);
    rd("R6 readback", 2'd1);
    wr("R2 R8 clear 0 req 1", 64'h2100);
    wr("R6 clear+req same bit", 64'h1100);
    rd("R2 R6 readback", 2'd3);
    op("R9 strobe 1,3", 1'b0, '0, 1'b0, 2'd0, 4'b1010);
    wr("R9 write no raise", 64'h0);
    wr("R2 clear iti1", 64'h20);
    op("R9 strobe beats clear", 1'b1, 64'h80, 1'b0, 2'd0, 4'b1000);
    rd("R9 readback", 2'd0);
    wr("R5 first claim", 64'h3_0000);
    wr("R5 second claim", 64'hC_0000);
    rd("R5 kept", 2'd1);
    wr("R4 set bid", 64'h20_0000);
    wr("R3 R4 clear byte then set", 64'h58_0000 | 64'h4_0000);
    rd("R3 readback", 2'd2);
    wr("R5 claim after clear", 64'hA_0000);
    rd("R5 readback", 2'd0);
    wr("R7 rw A", 64'h0000_0A00_0000_0000);
    rd("R7 readback A", 2'd3);
    op("R10 write+read same cycle", 1'b1, 64'h0000_0500_0000_0000, 1'b1, 2'd1, 4'd0);
    rd("R7 R10 readback 5", 2'd1);
    wr("R2 bit28", 64'h1000_0000);
    wr("R11 ignored bits", ~64'h0000_0F00_10FF_FFF0);
    rd("R11 readback", 2'd2);
    wr("R2 clear all pending", 64'h0FF0);
    rd("R2 final", 2'd0);
    repeat (2) @(negedge clk);
    check("R10 rdata holds", rdata, {model[63:2], 2'd0});
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule